// File: doc/BRIEF.md
# Floating-Point Min/Max Selection Unit

This block picks one of two IEEE-754 operands according to a 2-bit operation code: the signed minimum, the signed maximum, the operand of smaller magnitude, or the operand of larger magnitude. It never computes a new value. The chosen input leaves the block bit for bit as it arrived, so a signaling NaN, a negative zero or an infinity keeps its exact encoding. It does not round, raise flags or quiet NaNs.

One input selects single or double precision. In single precision only the low 32 bits of each operand are examined. The result carries the chosen low word with the upper word cleared.

The unit sits in an FPU execute stage, with one register stage between a valid strobe on the inputs and a valid strobe on the result. At the instruction level, the ft register feeds operand `a` and the fs register feeds operand `b`. Every decision is made with integer comparisons of the encodings: a NaN detector per operand, a sign-magnitude ordering comparator and an unsigned magnitude comparator.

Top module: `fpmm_unit`

## Requirements
- R1: `valid_out` is high in the cycle after a clock edge that sampled `valid_in` high, and low after an edge that sampled it low. A synchronous active-low `rst_n` clears `valid_out` and `result` to 0. `result` keeps its value while `valid_in` is low.
- R2: Every result equals one of the two effective operands bit for bit. In double precision an effective operand is the whole 64-bit input; in single precision it is the input's low 32 bits with the upper 32 bits zero.
- R3: When both operands are NaN, the result is `a`, for every operation.
- R4: When exactly one operand is NaN, the result is the other operand, for every operation.
- R5: With `op`=2'b00 (minimum) and no NaN, the result is `b` if b < a, `a` if a < b. Infinities are ordinary values, so -inf wins against any non-NaN value.
- R6: With `op`=2'b01 (maximum) and no NaN, the result is `b` if b > a, `a` if a > b. +inf wins against any non-NaN value.
- R7: When the two values compare equal, including +0 against -0, the minimum returns the operand whose sign bit is set and the maximum returns the operand whose sign bit is clear. With identical encodings the result is `a`.
- R8: With `op`=2'b10 (smaller magnitude) and no NaN, the operand with the strictly smaller absolute value is returned. When the magnitudes are equal, the result follows the minimum rules of R5 and R7.
- R9: With `op`=2'b11 (larger magnitude) and no NaN, the operand with the strictly larger absolute value is returned, so ±inf wins against every finite value. When the magnitudes are equal, the result follows the maximum rules of R6 and R7, so +0 is chosen over -0.
- R10: With `is_double`=0 the upper 32 bits of both operands have no effect on the result, and the upper 32 bits of the result are zero.
- R11: An operand is NaN exactly when its exponent field is all ones and its mantissa is nonzero. The double layout is sign bit 63, exponent bits 62:52, mantissa bits 51:0. The single layout is sign bit 31, exponent bits 30:23, mantissa bits 22:0. An all-ones exponent with a zero mantissa is an infinity, not a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operands and operation are valid this cycle |
| is_double | input | 1 | 1 = double precision, 0 = single precision |
| op | input | 2 | 00 minimum, 01 maximum, 10 smaller magnitude, 11 larger magnitude |
| a | input | 64 | Operand a (from ft) |
| b | input | 64 | Operand b (from fs) |
| valid_out | output | 1 | Result is valid |
| result | output | 64 | Selected operand, registered |

## Verification
The assertions that relate the result to the operands read the inputs one cycle back through `$past`. They therefore assume that `a`, `b`, `op` and `is_double` are meaningful in every cycle where `valid_in` is high, and that those inputs are never X at a sampling edge. The bench meets this by driving every input to a defined value from time zero. It changes the inputs only on the falling clock edge, always together with `valid_in`, and when idle it returns them to zero with `valid_in` low. The randomized operands are produced by a deterministic shift generator, so no undefined value reaches the unit.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

  typedef enum logic [1:0] {
    OP_MIN  = 2'b00,
    OP_MAX  = 2'b01,
    OP_MINA = 2'b10,
    OP_MAXA = 2'b11
  } fpmm_op_e;

  // Returns 1 when operand b is the selected result.
  function automatic logic fpmm_take_b(
    input fpmm_op_e op,
    input logic     a_nan,
    input logic     b_nan,
    input logic     b_sign,
    input logic     a_lt_b,
    input logic     b_lt_a,
    input logic     ma_lt_mb,
    input logic     mb_lt_ma
  );
    logic min_pick, max_pick;
    // Signed minimum / maximum; equal values resolved by sign bit of b (R7)
    min_pick = b_lt_a ? 1'b1 : (a_lt_b ? 1'b0 : b_sign);
    max_pick = a_lt_b ? 1'b1 : (b_lt_a ? 1'b0 : ~b_sign);
    if (a_nan && b_nan)      return 1'b0;   // R3
    else if (a_nan)          return 1'b1;   // R4
    else if (b_nan)          return 1'b0;   // R4
    else begin
      case (op)
        OP_MIN:  return min_pick;
        OP_MAX:  return max_pick;
        OP_MINA: return mb_lt_ma ? 1'b1 : (ma_lt_mb ? 1'b0 : min_pick);
        default: return ma_lt_mb ? 1'b1 : (mb_lt_ma ? 1'b0 : max_pick);
      endcase
    end
  endfunction

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify #(
  parameter int D_EXP_W = 11,
  parameter int D_MAN_W = 52,
  parameter int S_EXP_W = 8,
  parameter int S_MAN_W = 23,
  localparam int DW    = 1 + D_EXP_W + D_MAN_W,
  localparam int SW    = 1 + S_EXP_W + S_MAN_W,
  localparam int MAG_W = DW - 1
) (
  input  logic             is_double,
  input  logic [DW-1:0]    operand,
  output logic [DW-1:0]    clean,
  output logic             sign,
  output logic [MAG_W-1:0] mag,
  output logic             is_nan
);

  logic d_nan, s_nan;

  // NaN: exponent all ones, mantissa nonzero (R11)
  assign d_nan = (&operand[DW-2 -: D_EXP_W]) && (|operand[D_MAN_W-1:0]);
  assign s_nan = (&operand[SW-2 -: S_EXP_W]) && (|operand[S_MAN_W-1:0]);

  always_comb begin
    if (is_double) begin
      clean  = operand;
      sign   = operand[DW-1];
      mag    = operand[MAG_W-1:0];
      is_nan = d_nan;
    end else begin
      clean  = {{(DW-SW){1'b0}}, operand[SW-1:0]};
      sign   = operand[SW-1];
      mag    = {{(DW-SW){1'b0}}, operand[SW-2:0]};
      is_nan = s_nan;
    end
  end

endmodule

// File: rtl/fpmm_compare.sv
module fpmm_compare #(
  parameter int MAG_W = 63
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic             a_lt_b,
  output logic             b_lt_a,
  output logic             ma_lt_mb,
  output logic             mb_lt_ma
);

  // Sign-magnitude ordering; +0 and -0 are equal.
  function automatic logic sm_less(
    input logic sx, input logic [MAG_W-1:0] mx,
    input logic sy, input logic [MAG_W-1:0] my
  );
    if (mx == '0 && my == '0) return 1'b0;
    else if (sx != sy)        return sx;
    else if (!sx)             return mx < my;
    else                      return mx > my;
  endfunction

  assign ma_lt_mb = a_mag < b_mag;
  assign mb_lt_ma = b_mag < a_mag;
  assign a_lt_b   = sm_less(a_sign, a_mag, b_sign, b_mag);
  assign b_lt_a   = sm_less(b_sign, b_mag, a_sign, a_mag);

endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter int D_EXP_W = 11,
  parameter int D_MAN_W = 52,
  parameter int S_EXP_W = 8,
  parameter int S_MAN_W = 23,
  localparam int DW    = 1 + D_EXP_W + D_MAN_W,
  localparam int SW    = 1 + S_EXP_W + S_MAN_W,
  localparam int MAG_W = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic          is_double,
  input  logic [1:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          valid_out,
  output logic [DW-1:0] result
);

  logic [DW-1:0]    opnd  [2];
  logic [DW-1:0]    clean [2];
  logic             sgn   [2];
  logic [MAG_W-1:0] mag   [2];
  logic             nan   [2];

  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpmm_classify #(
      .D_EXP_W(D_EXP_W), .D_MAN_W(D_MAN_W),
      .S_EXP_W(S_EXP_W), .S_MAN_W(S_MAN_W)
    ) u_cls (
      .is_double(is_double),
      .operand  (opnd[i]),
      .clean    (clean[i]),
      .sign     (sgn[i]),
      .mag      (mag[i]),
      .is_nan   (nan[i])
    );
  end

  logic a_lt_b, b_lt_a, ma_lt_mb, mb_lt_ma;

  fpmm_compare #(.MAG_W(MAG_W)) u_cmp (
    .a_sign  (sgn[0]),
    .a_mag   (mag[0]),
    .b_sign  (sgn[1]),
    .b_mag   (mag[1]),
    .a_lt_b  (a_lt_b),
    .b_lt_a  (b_lt_a),
    .ma_lt_mb(ma_lt_mb),
    .mb_lt_ma(mb_lt_ma)
  );

  logic          take_b;
  logic [DW-1:0] chosen;
  logic          no_nan;

  assign take_b = fpmm_take_b(fpmm_op_e'(op), nan[0], nan[1], sgn[1],
                              a_lt_b, b_lt_a, ma_lt_mb, mb_lt_ma);
  assign chosen = take_b ? clean[1] : clean[0];
  assign no_nan = !nan[0] && !nan[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) result <= chosen;
    end
  end

  // R1: one-cycle latency of the valid strobe
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  // R2: bit-exact pass-through of an effective operand
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> (result == $past(clean[0]) || result == $past(clean[1])));
  // R3: both NaN gives a
  a_r3_both_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && nan[0] && nan[1]) |=> result == $past(clean[0]));
  // R4: single NaN gives the other operand
  a_r4_one_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && nan[0] && !nan[1]) |=> result == $past(clean[1]));
  // R5: strictly smaller b wins the minimum
  a_r5_min_order: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && no_nan && op == 2'b00 && b_lt_a) |=> result == $past(clean[1]));
  // R9: strictly larger |a| wins the larger-magnitude selection
  a_r9_maxa_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && no_nan && op == 2'b11 && mb_lt_ma) |=> result == $past(clean[0]));
  // R10: single precision clears the upper word
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !is_double) |=> result[DW-1:SW] == '0);

endmodule

// File: tb/tb_fpmm_unit.sv
module tb_fpmm_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic        is_double = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        valid_out;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  fpmm_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .is_double(is_double),
    .op(op), .a(a), .b(b), .valid_out(valid_out), .result(result)
  );

  localparam logic [63:0] DP1  = 64'h3FF0000000000000, DN1 = 64'hBFF0000000000000;
  localparam logic [63:0] DP2  = 64'h4000000000000000, DN2 = 64'hC000000000000000;
  localparam logic [63:0] DP3  = 64'h4008000000000000, DN3 = 64'hC008000000000000;
  localparam logic [63:0] DPZ  = 64'h0, DNZ = 64'h8000000000000000;
  localparam logic [63:0] DPI  = 64'h7FF0000000000000, DNI = 64'hFFF0000000000000;
  localparam logic [63:0] DQN  = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001;
  localparam logic [63:0] DNN  = 64'hFFF8000000000123;

  // Reference model: map each value onto a signed integer key
  function automatic bit ref_nan(input logic [63:0] x, input bit dbl);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [63:0] ref_eff(input logic [63:0] x, input bit dbl);
    return dbl ? x : {32'h0, x[31:0]};
  endfunction

  function automatic logic [63:0] ref_abs(input logic [63:0] x, input bit dbl);
    return dbl ? {1'b0, x[62:0]} : {33'h0, x[30:0]};
  endfunction

  function automatic bit ref_neg(input logic [63:0] x, input bit dbl);
    return dbl ? x[63] : x[31];
  endfunction

  function automatic logic signed [64:0] ref_key(input logic [63:0] x, input bit dbl);
    logic signed [64:0] m;
    m = $signed({1'b0, ref_abs(x, dbl)});
    return ref_neg(x, dbl) ? -m : m;
  endfunction

  function automatic logic [63:0] ref_sel(input logic [1:0] o, input bit dbl,
                                          input logic [63:0] x, input logic [63:0] y);
    logic [63:0] ex, ey, ax, ay;
    logic signed [64:0] kx, ky;
    logic [63:0] lo, hi;
    ex = ref_eff(x, dbl); ey = ref_eff(y, dbl);
    if (ref_nan(x, dbl)) return ref_nan(y, dbl) ? ex : ey;
    if (ref_nan(y, dbl)) return ex;
    kx = ref_key(x, dbl); ky = ref_key(y, dbl);
    ax = ref_abs(x, dbl); ay = ref_abs(y, dbl);
    if (ky < kx) begin lo = ey; hi = ex; end
    else if (kx < ky) begin lo = ex; hi = ey; end
    else begin
      lo = ref_neg(y, dbl) ? ey : ex;
      hi = ref_neg(y, dbl) ? ex : ey;
    end
    case (o)
      2'b00: return lo;
      2'b01: return hi;
      2'b10: return (ax < ay) ? ex : (ay < ax) ? ey : lo;
      default: return (ax > ay) ? ex : (ay > ax) ? ey : hi;
    endcase
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation, sample the registered result after the edge
  task automatic run_op(input string req, input logic [1:0] o, input bit dbl,
                        input logic [63:0] x, input logic [63:0] y, input logic [63:0] exp);
    @(negedge clk);
    valid_in = 1'b1; op = o; is_double = dbl; a = x; b = y;
    @(posedge clk); #1;
    check64(req, {63'h0, valid_out}, 64'h1);
    check64(req, result, exp);
    @(negedge clk);
    valid_in = 1'b0; op = 2'b00; is_double = 1'b0; a = '0; b = '0;
  endtask

  task automatic run_ref(input string req, input logic [1:0] o, input bit dbl,
                         input logic [63:0] x, input logic [63:0] y);
    run_op(req, o, dbl, x, y, ref_sel(o, dbl, x, y));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    check64("R1 reset valid", {63'h0, valid_out}, 64'h0);
    check64("R1 reset result", result, 64'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_hold;
    run_op("R1", 2'b01, 1'b1, DP1, DP2, DP2);
    @(negedge clk);
    valid_in = 1'b0; op = 2'b00; is_double = 1'b1; a = DN3; b = DNI;
    @(posedge clk); #1;
    check64("R1 idle valid", {63'h0, valid_out}, 64'h0);
    check64("R1 hold result", result, DP2);
    @(negedge clk); a = '0; b = '0; is_double = 1'b0;
  endtask

  task automatic t_nan;
    run_op("R3 both nan", 2'b00, 1'b1, DSN, DQN, DSN);
    run_op("R3 both nan maxa", 2'b11, 1'b1, DNN, DSN, DNN);
    run_op("R4 nan a min", 2'b00, 1'b1, DQN, DP3, DP3);
    run_op("R4 nan b max", 2'b01, 1'b1, DN2, DSN, DN2);
    run_op("R4 nan a mina", 2'b10, 1'b1, DNN, DPI, DPI);
    run_op("R4 nan b maxa", 2'b11, 1'b1, DNZ, DQN, DNZ);
    run_op("R11 inf not nan", 2'b01, 1'b1, DPI, DP1, DPI);
    run_op("R11 snan passed", 2'b00, 1'b1, DSN, DSN, DSN);
  endtask

  task automatic t_minmax;
    run_op("R5 min b", 2'b00, 1'b1, DP2, DN1, DN1);
    run_op("R5 min a", 2'b00, 1'b1, DN3, DN1, DN3);
    run_op("R5 min -inf", 2'b00, 1'b1, DN3, DNI, DNI);
    run_op("R6 max b", 2'b01, 1'b1, DN2, DP1, DP1);
    run_op("R6 max a neg", 2'b01, 1'b1, DN1, DN3, DN1);
    run_op("R6 max +inf", 2'b01, 1'b1, DPI, DP3, DPI);
  endtask

  task automatic t_zeros;
    run_op("R7 min -0 b", 2'b00, 1'b1, DPZ, DNZ, DNZ);
    run_op("R7 min -0 a", 2'b00, 1'b1, DNZ, DPZ, DNZ);
    run_op("R7 max +0 b", 2'b01, 1'b1, DNZ, DPZ, DPZ);
    run_op("R7 max +0 a", 2'b01, 1'b1, DPZ, DNZ, DPZ);
  endtask

  task automatic t_mag;
    run_op("R8 mina smaller b", 2'b10, 1'b1, DN3, DP1, DP1);
    run_op("R8 mina tie", 2'b10, 1'b1, DP3, DN3, DN3);
    run_op("R8 mina zeros", 2'b10, 1'b1, DPZ, DNZ, DNZ);
    run_op("R9 maxa larger a", 2'b11, 1'b1, DN3, DP2, DN3);
    run_op("R9 maxa tie", 2'b11, 1'b1, DN2, DP2, DP2);
    run_op("R9 maxa zeros", 2'b11, 1'b1, DNZ, DPZ, DPZ);
    run_op("R9 maxa -inf", 2'b11, 1'b1, DP3, DNI, DNI);
  endtask

  task automatic t_single;
    run_op("R10 min upper ignored", 2'b00, 1'b0, 64'hFFFF_0000_4000_0000,
           64'h1234_5678_BF80_0000, 64'h0000_0000_BF80_0000);
    run_op("R10 max upper", 2'b01, 1'b0, 64'hAAAA_AAAA_3F80_0000,
           64'h5555_5555_4000_0000, 64'h0000_0000_4000_0000);
    run_op("R11 single nan", 2'b00, 1'b0, 64'h0000_0000_7FC0_0000,
           64'hFFFF_FFFF_C040_0000, 64'h0000_0000_C040_0000);
    run_op("R11 single inf", 2'b11, 1'b0, 64'h0000_0000_7F80_0000,
           64'h0000_0000_C040_0000, 64'h0000_0000_7F80_0000);
    run_op("R7 single zeros", 2'b00, 1'b0, 64'h0, 64'hFFFF_FFFF_8000_0000,
           64'h0000_0000_8000_0000);
    run_op("R10 upper nan ignored", 2'b01, 1'b0, DQN, 64'h0000_0000_3F80_0000,
           64'h0000_0000_3F80_0000);
  endtask

  task automatic t_sweep;
    logic [63:0] s = 64'h9E3779B97F4A7C15;
    logic [63:0] x, y;
    for (int i = 0; i < 300; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      x = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      y = s;
      if (i % 7 == 0) y[62:52] = 11'h7FF;
      if (i % 11 == 0) x[30:23] = 8'hFF;
      if (i % 5 == 0) y = {x[63] ^ y[0], x[62:0]};
      if (i % 13 == 0) y = {y[31:0], x[31] ^ 1'b1, x[30:0]};
      run_ref("R2 sweep", 2'(i), (i % 3) != 0, x, y);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hold();
    t_nan();
    t_minmax();
    t_zeros();
    t_mag();
    t_single();
    t_sweep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule